// File: doc/BRIEF.md
# Delayed Bus Read-Drive Controller

This block decides when an expansion card may start putting read data on a shared 8-bit slot data bus. A card access begins when the slot select strobe goes active together with the rising edge of the bus phase clock PH0. At that moment the motherboard's own data buffers may still be driving the bus. If the card turned its transceiver on at once, both sides would drive the same lines for tens of nanoseconds, causing current surges and ringing. The controller keeps the card's transceiver off during a guard interval. It then turns all eight lines on together and keeps them on until the access ends.

Every input is asynchronous to the fast local clock. The block passes each one through a two-stage synchroniser and finds the bus edges from the synchronised copies. The guard interval is set in one of two ways. In counter mode it is a fixed number of local clock cycles; the default of 15 cycles at 125 MHz is 120 ns. In edge mode it ends at the first rising edge of the 7 MHz bus clock that occurs after the access has started. The mode is sampled when each access starts.

For write accesses the transceiver stays off and faces the card. The block gives a single-cycle capture strobe a set number of local cycles before PH0 is expected to fall. The time of that fall is predicted from the measured length of the previous PH0 high phase.

Top module: `bus_read_drive_ctrl`

## Requirements
- R1: While reset is low, and on an idle bus after reset, `xcvr_en`, `xcvr_to_bus` and `wr_capture` are 0. Asserting reset drops `xcvr_en` at once, without waiting for a clock edge.
- R2: Counter mode (`mode_c7` = 0), read access: count the first local clock edge after `slot_sel_n` falls and `ph0` rises as edge 1. `xcvr_en` is 0 through edge GUARD_CYCLES+2 and first reads 1 after edge GUARD_CYCLES+3.
- R3: During a read access, `xcvr_to_bus` is 1 from edge 3 until the access ends. `xcvr_en` is never 1 while `xcvr_to_bus` is 0.
- R4: Edge mode (`mode_c7` = 1): when `clk7m` rises between edge k and edge k+1, with k ≥ 1, `xcvr_en` first reads 1 after edge k+3. A 7 MHz rise that arrives before edge 1 does not end the guard.
- R5: `xcvr_en` reads 0 after the second local edge following either `slot_sel_n` rising or `ph0` falling, whichever happens first.
- R6: In a write access (`rd_wr_n` = 0 at the start), `xcvr_en` and `xcvr_to_bus` stay 0 for the whole access.
- R7: In a write access, `wr_capture` is high for exactly one cycle, after edge H−CAP_LEAD+2. H is the number of local edges at which `ph0` was high during the previous PH0 high phase.
- R8: Before any PH0 high phase has been measured since reset, H is taken as DEFAULT_HIGH.
- R9: The timing mode is latched at the start of an access. Changing `mode_c7` or toggling `clk7m` later in that access leaves the counter-mode timing of R2 unchanged.
- R10: When the access ends before the guard interval is over, `xcvr_en` stays 0 for that whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock, much faster than the bus clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel_n | input | 1 | Slot select strobe, active low |
| ph0 | input | 1 | Bus phase clock; access data phase while high |
| clk7m | input | 1 | 7 MHz bus clock |
| rd_wr_n | input | 1 | 1 = read from card, 0 = write to card |
| mode_c7 | input | 1 | 0 = counter guard, 1 = 7 MHz edge guard |
| xcvr_en | output | 1 | Transceiver enable, all eight data lines together |
| xcvr_to_bus | output | 1 | Transceiver direction, 1 = card drives bus |
| wr_capture | output | 1 | One-cycle strobe to latch write data |

## Verification
Every bus input reaches the logic two local edges after it changes. The access state changes one edge later. So the transceiver direction is due after edge 3, the counter-mode enable after edge GUARD_CYCLES+3, and the edge-mode enable three edges after the 7 MHz rise. The enable is removed two edges after the access ends. The write strobe is due H−CAP_LEAD+2 edges into a write. The bench changes inputs just after a sampling point and samples 2 ns after each rising edge. It counts edges from the first edge after each stimulus and records the edge number at which each output first and last reads high. It compares those numbers with values worked out from these counts.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GUARD = 2'd1,
    ST_DRIVE = 2'd2,
    ST_WRITE = 2'd3
  } acc_state_t;

  typedef struct packed {
    logic sel;
    logic ph0;
    logic c7;
    logic rd;
  } bus_samp_t;

  localparam int BUS_SAMP_W = $bits(bus_samp_t);

endpackage

// File: rtl/bdr_sync.sv
module bdr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg_d;
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/bdr_access_fsm.sv
module bdr_access_fsm
  import bdr_pkg::*;
#(
  parameter int GUARD_CYCLES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_sel,
  input  logic s_ph0,
  input  logic s_c7,
  input  logic s_rd,
  input  logic mode_c7,
  output logic xcvr_en,
  output logic xcvr_to_bus,
  output logic in_write
);

  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYCLES - 1);

  acc_state_t     state_q, state_d;
  logic [GW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;
  logic           mode_q, mode_d;
  logic           active, active_q;
  logic           c7_q;
  logic           start, c7_rise, guard_done;

  assign active  = s_sel & s_ph0;
  assign start   = active & ~active_q;
  assign c7_rise = s_c7 & ~c7_q;
  assign guard_done = mode_q ? c7_rise : (cnt_q == GUARD_LAST);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_d = mode_c7;
          cnt_en = 1'b1;
          cnt_d  = '0;
          state_d = s_rd ? ST_GUARD : ST_WRITE;
        end
      end
      ST_GUARD: begin
        if (!active) begin
          state_d = ST_IDLE;
        end else if (guard_done) begin
          state_d = ST_DRIVE;
        end else if (cnt_q != GUARD_LAST) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      ST_DRIVE: if (!active) state_d = ST_IDLE;
      ST_WRITE: if (!active) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      active_q <= 1'b0;
      c7_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      active_q <= active;
      c7_q     <= s_c7;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign xcvr_en     = (state_q == ST_DRIVE) & active & s_rd;
  assign xcvr_to_bus = (state_q == ST_GUARD) | (state_q == ST_DRIVE);
  assign in_write    = (state_q == ST_WRITE);

  // R5: once the access strobe is gone, the next state is idle
  a_r5_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> state_q == ST_IDLE);

  // R2: counter-mode drive begins only after the full guard count
  a_r2_guard_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state_q == ST_DRIVE) && !mode_q) |-> $past(cnt_q) == GUARD_LAST);

  // R3: direction already faces the bus the cycle before enable rises
  a_r3_dir_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcvr_en) |-> $past(xcvr_to_bus));

  // R6: never drive during a write access
  a_r6_no_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |-> !xcvr_en && !xcvr_to_bus);

  // R9: mode stays fixed while an access is underway
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(mode_q));

endmodule

// File: rtl/bdr_wr_predict.sv
module bdr_wr_predict #(
  parameter int PH_W         = 8,
  parameter int CAP_LEAD     = 4,
  parameter int DEFAULT_HIGH = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_ph0,
  input  logic in_write,
  output logic wr_pulse
);

  localparam logic [PH_W-1:0] PH_MAX  = {PH_W{1'b1}};
  localparam logic [PH_W-1:0] LEAD    = PH_W'(CAP_LEAD);
  localparam logic [PH_W-1:0] DEF_LEN = PH_W'(DEFAULT_HIGH);

  logic [PH_W-1:0] ph_cnt_q, ph_cnt_d;
  logic [PH_W-1:0] last_q;
  logic            ph0_q;
  logic            ph0_fall;
  logic            last_en;
  logic            lead_ok;

  assign ph0_fall = ~s_ph0 & ph0_q;
  assign last_en  = ph0_fall;

  always_comb begin
    if (!s_ph0)                ph_cnt_d = '0;
    else if (ph_cnt_q != PH_MAX) ph_cnt_d = ph_cnt_q + 1'b1;
    else                       ph_cnt_d = ph_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt_q <= '0;
      ph0_q    <= 1'b0;
    end else begin
      ph_cnt_q <= ph_cnt_d;
      ph0_q    <= s_ph0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= DEF_LEN;
    else if (last_en) last_q <= ph_cnt_q;
  end

  assign lead_ok  = last_q > LEAD;
  assign wr_pulse = in_write & s_ph0 & lead_ok & (ph_cnt_q == last_q - LEAD);

  // R7: the capture strobe lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R7: the phase counter restarts from zero on every PH0 high phase
  a_r7_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ph0) |=> ph_cnt_q == PH_W'(1));

endmodule

// File: rtl/bus_read_drive_ctrl.sv
module bus_read_drive_ctrl
  import bdr_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 15,
  parameter int PH_W         = 8,
  parameter int CAP_LEAD     = 4,
  parameter int DEFAULT_HIGH = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_sel_n,
  input  logic ph0,
  input  logic clk7m,
  input  logic rd_wr_n,
  input  logic mode_c7,
  output logic xcvr_en,
  output logic xcvr_to_bus,
  output logic wr_capture
);

  logic      rst_m, rst_sync_n;
  bus_samp_t raw, syn;
  logic      in_write;
  logic      en_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  assign raw.sel = ~slot_sel_n;
  assign raw.ph0 = ph0;
  assign raw.c7  = clk7m;
  assign raw.rd  = rd_wr_n;

  bdr_sync #(.W(BUS_SAMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (raw),
    .dout (syn)
  );

  bdr_access_fsm #(.GUARD_CYCLES(GUARD_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .s_sel      (syn.sel),
    .s_ph0      (syn.ph0),
    .s_c7       (syn.c7),
    .s_rd       (syn.rd),
    .mode_c7    (mode_c7),
    .xcvr_en    (en_core),
    .xcvr_to_bus(xcvr_to_bus),
    .in_write   (in_write)
  );

  bdr_wr_predict #(
    .PH_W(PH_W), .CAP_LEAD(CAP_LEAD), .DEFAULT_HIGH(DEFAULT_HIGH)
  ) u_pred (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .s_ph0   (syn.ph0),
    .in_write(in_write),
    .wr_pulse(wr_capture)
  );

  assign xcvr_en = en_core & rst_n;

  // R6: read drive and write capture never coincide
  a_r6_drive_vs_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(xcvr_en && wr_capture));

  // R1: outputs quiet in the first cycle after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !xcvr_en && !xcvr_to_bus && !wr_capture);

endmodule

// File: tb/bus_read_drive_ctrl_bench.sv
module bus_read_drive_ctrl_bench;

  localparam int G = 15;
  localparam int L = 4;
  localparam int D = 60;

  logic clk, rst_n, slot_sel_n, ph0, clk7m, rd_wr_n, mode_c7;
  logic xcvr_en, xcvr_to_bus, wr_capture;

  int n_chk = 0;
  int n_bad = 0;

  bus_read_drive_ctrl #(
    .SYNC_STAGES(2), .GUARD_CYCLES(G), .PH_W(8), .CAP_LEAD(L), .DEFAULT_HIGH(D)
  ) u_bus_read_drive_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_sel_n(slot_sel_n), .ph0(ph0),
    .clk7m(clk7m), .rd_wr_n(rd_wr_n), .mode_c7(mode_c7),
    .xcvr_en(xcvr_en), .xcvr_to_bus(xcvr_to_bus), .wr_capture(wr_capture)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    int mode; int rd; int c7k; int hold; int first; int last; int cap;
  } vec_t;

  // c7k: -1 no 7 MHz rise, 0 rise before edge 1, k rise after edge k
  localparam vec_t VEC [9] = '{
    '{0, 0, -1, 70, 0,  0,  D-L+2},  // R8 default length
    '{0, 1, -1, 40, G+3, 41, 0},     // R2
    '{0, 0, -1, 40, 0,  0,  38},     // R7 prev 40
    '{1, 1,  5, 30, 8,  31, 0},      // R4
    '{1, 1,  0, 30, 0,  0,  0},      // R4 early rise ignored
    '{0, 0, -1, 50, 0,  0,  28},     // R7 prev 30
    '{1, 1,  1, 20, 4,  21, 0},      // R4 k=1
    '{0, 1, -1, 10, 0,  0,  0},      // R10 short access
    '{0, 0, -1, 20, 0,  0,  8}       // R7 prev 10
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_access(input vec_t v, output int first, output int last,
                            output int cap, output int ncap, output int dirbad);
    first = 0; last = 0; cap = 0; ncap = 0; dirbad = 0;
    mode_c7 = v.mode[0];
    rd_wr_n = v.rd[0];
    clk7m   = (v.c7k == 0);
    slot_sel_n = 1'b0;
    ph0 = 1'b1;
    for (int e = 1; e <= v.hold + 6; e++) begin
      step();
      if (xcvr_en) begin
        if (first == 0) first = e;
        last = e;
        if (!xcvr_to_bus) dirbad++;
      end
      if (v.rd == 0 && xcvr_to_bus) dirbad++;
      if (wr_capture) begin
        ncap++;
        cap = e;
      end
      if (e == v.c7k) clk7m = 1'b1;
      if (e == v.hold) begin
        ph0 = 1'b0;
        slot_sel_n = 1'b1;
      end
    end
    clk7m = 1'b0;
    idle(4);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int first, last, cap, ncap, dirbad;
    rst_n = 1'b0; slot_sel_n = 1'b1; ph0 = 1'b0; clk7m = 1'b0;
    rd_wr_n = 1'b1; mode_c7 = 1'b0;
    idle(3);
    chk("R1", "en in reset", int'(xcvr_en), 0);
    chk("R1", "dir in reset", int'(xcvr_to_bus), 0);
    chk("R1", "cap in reset", int'(wr_capture), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1", "en after reset", int'(xcvr_en), 0);
    chk("R1", "dir after reset", int'(xcvr_to_bus), 0);

    foreach (VEC[i]) begin
      run_access(VEC[i], first, last, cap, ncap, dirbad);
      chk(VEC[i].rd != 0 ? (VEC[i].mode != 0 ? "R4" : "R2") : "R6", "first enable edge", first, VEC[i].first);
      chk("R5", "last enable edge", last, VEC[i].last);
      chk(VEC[i].rd != 0 ? "R3" : "R6", "direction violations", dirbad, 0);
      chk(VEC[i].rd != 0 ? "R6" : "R7", "capture count", ncap, VEC[i].cap != 0 ? 1 : 0);
      chk(i == 0 ? "R8" : "R7", "capture edge", cap, VEC[i].cap);
    end

    // R9: mode and 7 MHz changes after the start leave counter timing alone
    begin
      int f9 = 0;
      mode_c7 = 1'b0; rd_wr_n = 1'b1; clk7m = 1'b0;
      slot_sel_n = 1'b0; ph0 = 1'b1;
      for (int e = 1; e <= 30; e++) begin
        step();
        if (xcvr_en && f9 == 0) f9 = e;
        if (e == 3) mode_c7 = 1'b1;
        if (e == 5) clk7m = 1'b1;
      end
      ph0 = 1'b0; slot_sel_n = 1'b1; clk7m = 1'b0; mode_c7 = 1'b0;
      idle(4);
      chk("R9", "first enable edge", f9, G + 3);
    end

    // R5: select released while PH0 stays high
    begin
      int l5 = 0;
      rd_wr_n = 1'b1; slot_sel_n = 1'b0; ph0 = 1'b1;
      for (int e = 1; e <= 40; e++) begin
        step();
        if (xcvr_en) l5 = e;
        if (e == 25) slot_sel_n = 1'b1;
      end
      ph0 = 1'b0;
      idle(4);
      chk("R5", "last enable edge on select release", l5, 26);
    end

    // R1: reset during drive removes the enable at once
    rd_wr_n = 1'b1; slot_sel_n = 1'b0; ph0 = 1'b1;
    idle(20);
    chk("R2", "enable during drive", int'(xcvr_en), 1);
    rst_n = 1'b0;
    #1;
    chk("R1", "enable on async reset", int'(xcvr_en), 0);
    slot_sel_n = 1'b1; ph0 = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    chk("R1", "direction after reset", int'(xcvr_to_bus), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule